// File: doc/BRIEF.md
# Synthesizer Configuration Register with Serial and Parallel Load

This block keeps the divider and test settings of a clock synthesizer: a 9-bit loop divider, a 2-bit output divider code and a 3-bit test selector. It can be written in two ways. The first is a three-wire serial port made of a bit clock, a data line and a load strobe. The second is a set of parallel divider pins with their own strobe. Both paths write one shared configuration store. That store behaves like a transparent latch. While the serial strobe is high it follows the serial shift register. While the parallel strobe is low it follows the parallel pins. Each strobe freezes the store on its closing edge.

The block is fully synchronous to a fast system clock. Every external input passes through a synchronizer of equal depth on each path, so data and strobes stay aligned. Strobe levels and the rising edge of the serial clock are then detected in the system clock domain. The reset values of the store match what undriven inputs would give: the parallel pins read high and the test field reads zero.

Top module: `synth_cfg_reg`

## Requirements
- R1: After reset the outputs are loop_div = 9'h1FF, out_div = 2'b11 and test_sel = 3'b000.
- R2: Each rising edge of ser_clk shifts ser_din into bit 0 of a 14-bit shift register, and the older bits move up by one place. A frame is sent most significant bit first. The frame layout is {test[2:0], out[1:0], loop[8:0]}, so bits 13:11 hold the test field, bits 10:9 the output code and bits 8:0 the loop divider. Changes on ser_din that come without a rising edge of ser_clk do not shift.
- R3: While ser_load is high and par_hold is high, all three outputs follow the shift register, including bits that are shifted in during that time.
- R4: While ser_load is low and par_hold is high, the outputs keep their value, even when more bits are shifted into the register.
- R5: While par_hold is low, loop_div and out_div follow par_loop and par_out.
- R6: While par_hold is high, changes on par_loop and par_out have no effect on the outputs.
- R7: A parallel load never changes test_sel.
- R8: When par_hold is low and ser_load is high at the same time, the parallel pins win for loop_div and out_div, and test_sel keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial bit clock; the block shifts on its rising edge |
| ser_din | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Serial strobe; the store is transparent while it is high |
| par_hold | input | 1 | Parallel strobe; the store is transparent while it is low |
| par_loop | input | 9 | Parallel loop divider value |
| par_out | input | 2 | Parallel output divider code |
| loop_div | output | 9 | Configured loop divider |
| out_div | output | 2 | Configured output divider code |
| test_sel | output | 3 | Configured test selector |

## Verification
A fault in the shift register stays hidden until the serial strobe opens. Once it opens, the outputs show the whole frame, usually off by one position or with one field swapped. The test field is a good place to catch this, because it can only be reached through the serial path. A fault in the store, such as a wrong priority or a missed freeze, shows at the outputs a few system clocks after the strobe or pin change that triggers it. That delay is the synchronizer depth plus one register. The bench therefore waits past this delay after each stimulus before it compares the outputs.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int LOOP_W  = 9;
  localparam int OUT_W   = 2;
  localparam int TEST_W  = 3;
  localparam int FRAME_W = TEST_W + OUT_W + LOOP_W;

  typedef struct packed {
    logic [TEST_W-1:0] test;
    logic [OUT_W-1:0]  outd;
    logic [LOOP_W-1:0] loop;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{test: '0, outd: '1, loop: '1};
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_rest
      assign stage_d = pipe_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[s] <= RST_VAL;
      else        pipe_q[s] <= stage_d;
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift
  import synth_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bclk,
  input  logic               bdat,
  output logic [FRAME_W-1:0] frame
);
  logic               bclk_prev_q;
  logic               shift_en;
  logic [FRAME_W-1:0] frame_d;
  logic [FRAME_W-1:0] frame_q;

  assign shift_en = bclk & ~bclk_prev_q;

  always_comb begin
    frame_d = frame_q;
    if (shift_en) frame_d = {frame_q[FRAME_W-2:0], bdat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev_q <= 1'b0;
      frame_q     <= '0;
    end else begin
      bclk_prev_q <= bclk;
      frame_q     <= frame_d;
    end
  end

  assign frame = frame_q;

  // R2: a rising bit clock shifts one place up, new bit enters at bit 0
  a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk && !bclk_prev_q) |=> (frame_q == {$past(frame_q[FRAME_W-2:0]), $past(bdat)}));
  // R2: no rising bit clock, no shift
  a_r2_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !(bclk && !bclk_prev_q) |=> $stable(frame_q));
endmodule

// File: rtl/synth_cfg_store.sv
module synth_cfg_store
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_open,
  input  logic              par_open,
  input  cfg_t              ser_cfg,
  input  logic [LOOP_W-1:0] pin_loop,
  input  logic [OUT_W-1:0]  pin_out,
  output cfg_t              cfg
);
  cfg_t cfg_d;
  cfg_t cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (par_open) begin
      cfg_d.loop = pin_loop;
      cfg_d.outd = pin_out;
    end else if (ser_open) begin
      cfg_d = ser_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // R3: serial-only transparency follows the shift register
  a_r3_ser_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_open && !par_open) |=> (cfg_q == $past(ser_cfg)));
  // R4 and R6: both strobes closed, store holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_open && !par_open) |=> $stable(cfg_q));
  // R5 and R8: parallel transparency follows the pins
  a_r5_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
    par_open |=> (cfg_q.loop == $past(pin_loop) && cfg_q.outd == $past(pin_out)));
  // R7: parallel loads never touch the test field
  a_r7_test_kept: assert property (@(posedge clk) disable iff (!rst_n)
    par_open |=> (cfg_q.test == $past(cfg_q.test)));
endmodule

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_load,
  input  logic              par_hold,
  input  logic [LOOP_W-1:0] par_loop,
  input  logic [OUT_W-1:0]  par_out,
  output logic [LOOP_W-1:0] loop_div,
  output logic [OUT_W-1:0]  out_div,
  output logic [TEST_W-1:0] test_sel
);
  localparam int IN_W = 4 + LOOP_W + OUT_W;
  localparam logic [IN_W-1:0] IN_RST = {3'b000, 1'b1, {LOOP_W{1'b1}}, {OUT_W{1'b1}}};

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IN_W-1:0]   in_raw;
  logic [IN_W-1:0]   in_s;
  logic              bclk_s, bdat_s, sload_s, phold_s;
  logic [LOOP_W-1:0] ploop_s;
  logic [OUT_W-1:0]  pout_s;
  logic [FRAME_W-1:0] frame;
  cfg_t              cfg;

  assign in_raw = {ser_clk, ser_din, ser_load, par_hold, par_loop, par_out};

  synth_cfg_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(in_raw), .q(in_s)
  );

  assign {bclk_s, bdat_s, sload_s, phold_s, ploop_s, pout_s} = in_s;

  synth_cfg_shift u_shift (
    .clk(clk), .rst_n(rst_int_n), .bclk(bclk_s), .bdat(bdat_s), .frame(frame)
  );

  synth_cfg_store u_store (
    .clk(clk), .rst_n(rst_int_n),
    .ser_open(sload_s), .par_open(~phold_s),
    .ser_cfg(cfg_t'(frame)), .pin_loop(ploop_s), .pin_out(pout_s),
    .cfg(cfg)
  );

  assign loop_div = cfg.loop;
  assign out_div  = cfg.outd;
  assign test_sel = cfg.test;

  // R1: outputs leave reset at their default values
  a_r1_reset_vals: assert property (@(posedge clk)
    $rose(rst_int_n) |-> (loop_div == '1 && out_div == '1 && test_sel == '0));
endmodule

// File: tb/synth_cfg_reg_tb.sv
module synth_cfg_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_din = 1'b0, ser_load = 1'b0, par_hold = 1'b1;
  logic [8:0] par_loop = 9'h1FF;
  logic [1:0] par_out = 2'b11;
  logic [8:0] loop_div;
  logic [1:0] out_div;
  logic [2:0] test_sel;

  int nvec = 0;
  int nfail = 0;
  logic [2:0] exp_t;

  always #10 clk = ~clk;

  synth_cfg_reg u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_load(ser_load), .par_hold(par_hold), .par_loop(par_loop), .par_out(par_out),
    .loop_div(loop_div), .out_div(out_div), .test_sel(test_sel)
  );

  // {mode(1=parallel), test[2:0], out[1:0], loop[8:0]}
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 3'b101, 2'b01, 9'h0A5},
    {1'b1, 3'b000, 2'b10, 9'h133},
    {1'b0, 3'b010, 2'b00, 9'h100},
    {1'b0, 3'b111, 2'b11, 9'h001},
    {1'b1, 3'b000, 2'b00, 9'h000},
    {1'b0, 3'b001, 2'b10, 9'h155},
    {1'b1, 3'b000, 2'b01, 9'h0FE},
    {1'b0, 3'b110, 2'b01, 9'h1C3}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [8:0] m, input logic [1:0] n,
                       input logic [2:0] t);
    nvec++;
    if (loop_div !== m || out_div !== n || test_sel !== t) begin
      nfail++;
      $display("FAIL %s: got loop=%h out=%b test=%b expected loop=%h out=%b test=%b",
               tag, loop_div, out_div, test_sel, m, n, t);
    end
  endtask

  task automatic shift_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) begin
      ser_din = f[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(2);
      ser_din = ~f[i];   // R2: data toggling without a clock edge must not shift
      wait_clk(2);
    end
  endtask

  task automatic pulse_sload;
    ser_load = 1'b1; wait_clk(6);
    ser_load = 1'b0; wait_clk(6);
  endtask

  task automatic par_write(input logic [8:0] m, input logic [1:0] n);
    par_loop = m; par_out = n;
    par_hold = 1'b0; wait_clk(6);
    par_hold = 1'b1; wait_clk(6);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin : main
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(6);
    check("R1 reset", 9'h1FF, 2'b11, 3'b000);
    exp_t = 3'b000;

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][14]) begin
        par_write(VEC[v][8:0], VEC[v][10:9]);
        check("R5/R7 parallel load", VEC[v][8:0], VEC[v][10:9], exp_t);
        par_loop = ~VEC[v][8:0]; par_out = ~VEC[v][10:9];
        wait_clk(6);
        check("R6 pins ignored when closed", VEC[v][8:0], VEC[v][10:9], exp_t);
      end else begin
        shift_frame(VEC[v][13:0]);
        check("R4 shift without load", loop_div, out_div, exp_t);
        pulse_sload;
        exp_t = VEC[v][13:11];
        check("R2/R3 serial load", VEC[v][8:0], VEC[v][10:9], exp_t);
      end
    end

    // R3: shifting while the serial strobe is open shows through at once
    ser_load = 1'b1; wait_clk(6);
    shift_frame({3'b011, 2'b10, 9'h0C9});
    check("R3 transparent serial", 9'h0C9, 2'b10, 3'b011);
    ser_load = 1'b0; wait_clk(6);
    exp_t = 3'b011;

    // R4: after the strobe closes, new frames stay in the shifter
    shift_frame({3'b100, 2'b01, 9'h1AA});
    check("R4 hold after close", 9'h0C9, 2'b10, exp_t);

    // R5: pins followed live while the parallel strobe is low
    par_hold = 1'b0; par_loop = 9'h011; par_out = 2'b00; wait_clk(6);
    check("R5 transparent parallel a", 9'h011, 2'b00, exp_t);
    par_loop = 9'h122; par_out = 2'b01; wait_clk(6);
    check("R5 transparent parallel b", 9'h122, 2'b01, exp_t);

    // R8: both open, pins win and test stays (shifter holds 100/01/1AA)
    ser_load = 1'b1; wait_clk(6);
    check("R8 both open", 9'h122, 2'b01, exp_t);
    par_hold = 1'b1; wait_clk(6);
    check("R3 serial after parallel closes", 9'h1AA, 2'b01, 3'b100);
    ser_load = 1'b0; wait_clk(6);

    // R1: reset again restores defaults
    rst_n = 1'b0; wait_clk(2);
    rst_n = 1'b1; wait_clk(6);
    check("R1 reset again", 9'h1FF, 2'b11, 3'b000);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule